// File: doc/BRIEF.md
# Dual-Slot Accumulator Processor Core

This block is a small accumulator processor core for a 40-bit word machine. Every memory word holds either one signed number or two 20-bit instructions packed side by side. The core reads one word and runs the instruction in the upper half. It then runs the instruction in the lower half from a holding register, with no second read. The program counter moves on only once both halves are done. Load, add and store are supported, and an all-zero instruction halts the core.

The core drives one single-port word memory with one cycle of read latency. Its address and write data come straight from the core's address and data holding registers. A one-cycle start pulse loads the program counter from `start_addr`, and the core runs until it meets a halt. Numbers are sign-magnitude, with the sign bit at the most significant position.

Top module: `acc_core`

## Requirements
- R1: While reset is asserted, `done`, `ovf` and `mem_we` are 0 and `mem_addr` is 0.
- R2: A cycle with `start` high while idle makes the first instruction word be fetched from `start_addr`. No other word is fetched first.
- R3: An instruction word is bits [39:20] (left slot) and bits [19:0] (right slot). Each slot is an 8-bit opcode in its upper bits and a 12-bit address field below it. The left slot runs first and the right slot runs second. The word after it is fetched from the next address only after both slots have run.
- R4: Opcode 8'h01 loads the memory word at the slot's address into the accumulator.
- R5: Opcode 8'h05 adds the memory word to the accumulator. With equal signs (bit 39), the 39-bit magnitudes are summed and the sign is kept.
- R6: When the signs differ, the add subtracts the smaller magnitude from the larger and takes the sign of the larger. A zero magnitude always gives a positive sign (bit 39 = 0).
- R7: If the magnitude sum carries out of 39 bits, it wraps modulo 2^39 and `ovf` is set. `ovf` then stays set until reset.
- R8: Opcode 8'h21 writes the accumulator to the slot's address in a single write cycle.
- R9: A slot with opcode 8'h00 halts the core. `done` then rises and stays high, `mem_we` stays low, `mem_addr` holds still, and the other slot of that word is not run.
- R10: Timing, counted in clock edges from the edge that samples `start`: a word fetch takes 2 edges, and load, add and store take 2 edges each. Any other nonzero opcode has no effect and takes 1 edge. A halt makes `done` high 1 edge after its fetch.
- R11: Only the low 10 bits of a 12-bit address field select the memory word. Bits [11:10] of the field are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin running from start_addr |
| start_addr | input | 10 | Address of the first instruction word |
| mem_addr | output | 10 | Memory word address |
| mem_we | output | 1 | Memory write enable |
| mem_wdata | output | 40 | Memory write data |
| mem_rdata | input | 40 | Memory read data, valid one cycle after the address |
| done | output | 1 | High once a halt instruction has run |
| ovf | output | 1 | Sticky add overflow flag |

## Verification
A wrong slot flag, program counter or operand address shows up as a missing or misplaced store, or as a wrong cycle count to `done`. The cycle count is exact for each program, so a single lost or extra state is seen as soon as the program halts. An adder fault in the sign, the magnitude or the carry shows up in the stored word and in `ovf` after one store. A faulty halt shows up at once, as activity on `mem_we` or `mem_addr` once `done` is high.

// File: rtl/acc_pkg.sv
package acc_pkg;
   localparam int WORD_W_D  = 40;
   localparam int OP_W_D    = 8;
   localparam int FLD_W_D   = 12;
   localparam int MADDR_W_D = 10;

   localparam logic [7:0] OPC_HALT  = 8'h00;
   localparam logic [7:0] OPC_LOAD  = 8'h01;
   localparam logic [7:0] OPC_ADD   = 8'h05;
   localparam logic [7:0] OPC_STORE = 8'h21;

   typedef enum logic [2:0] {
      ST_IDLE, ST_FETCH, ST_LATCH, ST_EXEC, ST_READ, ST_WRITE, ST_HALT
   } seq_state_t;
endpackage

// File: rtl/smag_adder.sv
module smag_adder #(
   parameter int W = 40
) (
   input  logic [W-1:0] a_i,
   input  logic [W-1:0] b_i,
   output logic [W-1:0] sum_o,
   output logic         carry_o
);
   localparam int MW = W - 1;

   if (W < 2) begin : g_bad_w
      $error("smag_adder: W must be at least 2");
   end

   logic          sa, sb, sgn;
   logic [MW-1:0] ma, mb, mag;
   logic [MW:0]   tot;

   assign sa = a_i[W-1];
   assign sb = b_i[W-1];
   assign ma = a_i[MW-1:0];
   assign mb = b_i[MW-1:0];
   assign tot = {1'b0, ma} + {1'b0, mb};

   always_comb begin
      carry_o = 1'b0;
      if (sa == sb) begin
         mag     = tot[MW-1:0];
         sgn     = sa;
         carry_o = tot[MW];
      end else if (ma >= mb) begin
         mag = ma - mb;
         sgn = sa;
      end else begin
         mag = mb - ma;
         sgn = sb;
      end
      if (mag == '0) sgn = 1'b0;
      sum_o = {sgn, mag};
   end
endmodule

// File: rtl/slot_split.sv
module slot_split #(
   parameter int WORD_W = 40,
   parameter int SLOT_W = 20
) (
   input  logic [WORD_W-1:0]          word_i,
   output logic [1:0][SLOT_W-1:0]     slot_o
);
   if (WORD_W != 2 * SLOT_W) begin : g_bad_split
      $error("slot_split: word must hold exactly two slots");
   end

   for (genvar s = 0; s < 2; s++) begin : g_slot
      localparam int BASE = (1 - s) * SLOT_W;
      assign slot_o[s] = word_i[BASE +: SLOT_W];
   end
endmodule

// File: rtl/slot_fields.sv
module slot_fields #(
   parameter int OP_W    = 8,
   parameter int FLD_W   = 12,
   parameter int MADDR_W = 10
) (
   input  logic [OP_W+FLD_W-1:0] slot_i,
   output logic [OP_W-1:0]       op_o,
   output logic [MADDR_W-1:0]    addr_o
);
   assign op_o   = slot_i[FLD_W +: OP_W];
   assign addr_o = slot_i[MADDR_W-1:0];

   if (MADDR_W > FLD_W) begin : g_bad_fld
      $error("slot_fields: memory address wider than address field");
   end else if (MADDR_W < FLD_W) begin : g_drop_hi
      logic unused_hi;
      assign unused_hi = ^slot_i[FLD_W-1:MADDR_W];
   end
endmodule

// File: rtl/acc_core.sv
module acc_core
   import acc_pkg::*;
#(
   parameter int WORD_W  = WORD_W_D,
   parameter int OP_W    = OP_W_D,
   parameter int FLD_W   = FLD_W_D,
   parameter int MADDR_W = MADDR_W_D
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   input  logic [MADDR_W-1:0] start_addr,
   output logic [MADDR_W-1:0] mem_addr,
   output logic               mem_we,
   output logic [WORD_W-1:0]  mem_wdata,
   input  logic [WORD_W-1:0]  mem_rdata,
   output logic               done,
   output logic               ovf
);
   localparam int SLOT_W = OP_W + FLD_W;

   if (WORD_W != 2 * SLOT_W) begin : g_bad_word
      $error("acc_core: WORD_W must equal two instruction slots");
   end
   if (OP_W != 8) begin : g_bad_op
      $error("acc_core: opcode encodings are 8 bits wide");
   end

   seq_state_t          state_q;
   logic [MADDR_W-1:0]  pc_q, mar_q;
   logic [WORD_W-1:0]   mbr_q, acc_q;
   logic [OP_W-1:0]     op_q;
   logic [SLOT_W-1:0]   pend_q;
   logic                right_q, ovf_q;

   logic [1:0][SLOT_W-1:0] slot_w;
   logic [OP_W-1:0]        l_op, p_op;
   logic [MADDR_W-1:0]     l_addr, p_addr;
   logic [WORD_W-1:0]      sum_w;
   logic                   carry_w, step_done, known_op;

   slot_split #(.WORD_W(WORD_W), .SLOT_W(SLOT_W)) u_split (
      .word_i(mem_rdata), .slot_o(slot_w));

   slot_fields #(.OP_W(OP_W), .FLD_W(FLD_W), .MADDR_W(MADDR_W)) u_left (
      .slot_i(slot_w[0]), .op_o(l_op), .addr_o(l_addr));

   slot_fields #(.OP_W(OP_W), .FLD_W(FLD_W), .MADDR_W(MADDR_W)) u_pend (
      .slot_i(pend_q), .op_o(p_op), .addr_o(p_addr));

   smag_adder #(.W(WORD_W)) u_add (
      .a_i(acc_q), .b_i(mem_rdata), .sum_o(sum_w), .carry_o(carry_w));

   assign known_op = (op_q == OPC_HALT) || (op_q == OPC_LOAD) ||
                     (op_q == OPC_ADD)  || (op_q == OPC_STORE);

   assign step_done = (state_q == ST_READ) || (state_q == ST_WRITE) ||
                      ((state_q == ST_EXEC) && !known_op);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         pc_q    <= '0;
         mar_q   <= '0;
         mbr_q   <= '0;
         acc_q   <= '0;
         op_q    <= '0;
         pend_q  <= '0;
         right_q <= 1'b0;
         ovf_q   <= 1'b0;
      end else begin
         case (state_q)
            ST_IDLE: if (start) begin
               pc_q    <= start_addr;
               mar_q   <= start_addr;
               state_q <= ST_FETCH;
            end
            ST_FETCH: state_q <= ST_LATCH;
            ST_LATCH: begin
               mbr_q   <= mem_rdata;
               pend_q  <= slot_w[1];
               op_q    <= l_op;
               mar_q   <= l_addr;
               right_q <= 1'b0;
               state_q <= ST_EXEC;
            end
            ST_EXEC: begin
               if (op_q == OPC_HALT) begin
                  state_q <= ST_HALT;
               end else if ((op_q == OPC_LOAD) || (op_q == OPC_ADD)) begin
                  state_q <= ST_READ;
               end else if (op_q == OPC_STORE) begin
                  mbr_q   <= acc_q;
                  state_q <= ST_WRITE;
               end
            end
            ST_READ: begin
               mbr_q <= mem_rdata;
               if (op_q == OPC_LOAD) begin
                  acc_q <= mem_rdata;
               end else begin
                  acc_q <= sum_w;
                  if (carry_w) ovf_q <= 1'b1;
               end
            end
            ST_WRITE: ;
            ST_HALT:  ;
            default:  state_q <= ST_IDLE;
         endcase

         if (step_done) begin
            if (!right_q) begin
               op_q    <= p_op;
               mar_q   <= p_addr;
               right_q <= 1'b1;
               state_q <= ST_EXEC;
            end else begin
               pc_q    <= pc_q + 1'b1;
               mar_q   <= pc_q + 1'b1;
               state_q <= ST_FETCH;
            end
         end
      end
   end

   assign mem_addr  = mar_q;
   assign mem_we    = (state_q == ST_WRITE);
   assign mem_wdata = mbr_q;
   assign done      = (state_q == ST_HALT);
   assign ovf       = ovf_q;
endmodule

// File: rtl/acc_core_chk.sv
module acc_core_chk #(
   parameter int MADDR_W = 10
) (
   input logic               clk,
   input logic               rst_n,
   input logic               mem_we,
   input logic [MADDR_W-1:0] mem_addr,
   input logic               done,
   input logic               ovf
);
   p_single_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |=> !mem_we);

   p_done_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> done);

   p_halt_no_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !mem_we);

   p_halt_addr_still_r9: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> $stable(mem_addr));

   p_ovf_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ovf |=> ovf);
endmodule

bind acc_core acc_core_chk #(.MADDR_W(MADDR_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .mem_we(mem_we), .mem_addr(mem_addr),
   .done(done), .ovf(ovf));

// File: tb/test_acc_core.sv
module test_acc_core;
   localparam logic [7:0] LD = 8'h01, AD = 8'h05, STO = 8'h21, HLT = 8'h00;
   localparam int NV = 8;
   localparam logic [39:0] VA [NV] = '{
      40'h00_0000_0005, 40'h80_0000_0005, 40'h00_0000_0009, 40'h00_0000_0004,
      40'h00_0000_0006, 40'h80_0000_0003, 40'h7F_FFFF_FFFF, 40'hFF_FFFF_FFFF};
   localparam logic [39:0] VB [NV] = '{
      40'h00_0000_0007, 40'h80_0000_0007, 40'h80_0000_0004, 40'h80_0000_0009,
      40'h80_0000_0006, 40'h00_0000_0003, 40'h00_0000_0002, 40'h80_0000_0003};
   localparam logic [39:0] VS [NV] = '{
      40'h00_0000_000C, 40'h80_0000_000C, 40'h00_0000_0005, 40'h80_0000_0005,
      40'h00_0000_0000, 40'h00_0000_0000, 40'h00_0000_0001, 40'h80_0000_0002};
   localparam logic VO [NV] = '{1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1};

   logic        clk = 1'b0, rst_n = 1'b0, start = 1'b0;
   logic [9:0]  start_addr = '0;
   logic [9:0]  mem_addr;
   logic        mem_we, done, ovf;
   logic [39:0] mem_wdata, mem_rdata;
   logic        tb_we = 1'b0;
   logic [9:0]  tb_addr = '0;
   logic [39:0] tb_wdata = '0;
   logic [39:0] mem [0:999];
   int          tests = 0, fails = 0;

   always #4 clk = ~clk;

   always @(posedge clk) begin
      if (tb_we) mem[tb_addr] <= tb_wdata;
      else if (mem_we) mem[mem_addr] <= mem_wdata;
      mem_rdata <= mem[mem_addr];
   end

   acc_core i_acc_core (
      .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
      .mem_addr(mem_addr), .mem_we(mem_we), .mem_wdata(mem_wdata),
      .mem_rdata(mem_rdata), .done(done), .ovf(ovf));

   function automatic logic [39:0] iw(input logic [7:0] lo, input logic [11:0] la,
                                      input logic [7:0] ro, input logic [11:0] ra);
      return {lo, la, ro, ra};
   endfunction

   task automatic chk(input string req, input logic [39:0] act, input logic [39:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic poke(input int a, input logic [39:0] d);
      @(negedge clk);
      tb_we = 1'b1; tb_addr = 10'(a); tb_wdata = d;
      @(negedge clk);
      tb_we = 1'b0;
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic run(input int sa, output int cyc);
      @(negedge clk);
      start = 1'b1; start_addr = 10'(sa);
      @(posedge clk);
      @(negedge clk);
      start = 1'b0;
      cyc = 0;
      while (!done && cyc < 200) begin
         @(posedge clk);
         cyc++;
         @(negedge clk);
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      int cyc;
      repeat (3) @(negedge clk);
      // R1: state held in reset
      chk("R1 done", 40'(done), 40'd0);
      chk("R1 ovf", 40'(ovf), 40'd0);
      chk("R1 mem_we", 40'(mem_we), 40'd0);
      chk("R1 mem_addr", 40'(mem_addr), 40'd0);

      // Table walk: LOAD 200 | ADD 201 ; STOR 202 | HALT
      for (int i = 0; i < NV; i++) begin
         string rq;
         rq = (i < 2) ? "R5" : ((i < 6) ? "R6" : "R7");
         do_reset();
         poke(0, iw(LD, 12'd200, AD, 12'd201));
         poke(1, iw(STO, 12'd202, HLT, 12'd0));
         poke(200, VA[i]);
         poke(201, VB[i]);
         poke(202, 40'h55_5555_5555);
         run(0, cyc);
         chk("R10 cycles", 40'(cyc), 40'd11);
         chk({rq, " sum"}, mem[202], VS[i]);
         chk({rq, " ovf"}, 40'(ovf), 40'(VO[i]));
      end

      // R4 and R11: load through an address field with high bits set
      do_reset();
      poke(0, iw(LD, 12'hCC8, STO, 12'd203));
      poke(1, iw(HLT, 12'd0, HLT, 12'd0));
      poke(200, 40'h00_0000_1234);
      poke(203, 40'd0);
      run(0, cyc);
      chk("R4 R11 load", mem[203], 40'h00_0000_1234);
      chk("R10 load-store cycles", 40'(cyc), 40'd9);

      // R2 R3 R7: start at 50, three words, overflow stays set
      do_reset();
      poke(0, iw(STO, 12'd202, HLT, 12'd0));
      poke(50, iw(LD, 12'd200, AD, 12'd201));
      poke(51, iw(AD, 12'd206, STO, 12'd202));
      poke(52, iw(HLT, 12'd0, HLT, 12'd0));
      poke(200, 40'h7F_FFFF_FFFF);
      poke(201, 40'h00_0000_0002);
      poke(206, 40'h00_0000_0003);
      poke(202, 40'h55_5555_5555);
      run(50, cyc);
      chk("R2 R3 result", mem[202], 40'h00_0000_0004);
      chk("R7 sticky ovf", 40'(ovf), 40'd1);
      chk("R3 cycles", 40'(cyc), 40'd15);

      // R10: unknown opcode is a one-cycle no-op
      do_reset();
      poke(0, iw(LD, 12'd200, 8'h7F, 12'd204));
      poke(1, iw(STO, 12'd204, HLT, 12'd0));
      poke(200, 40'h80_0000_004D);
      poke(204, 40'd0);
      run(0, cyc);
      chk("R10 nop value", mem[204], 40'h80_0000_004D);
      chk("R10 nop cycles", 40'(cyc), 40'd10);

      // R9: halt in left slot, right store must not run
      do_reset();
      poke(0, iw(HLT, 12'd0, STO, 12'd205));
      poke(205, 40'h00_0001_2345);
      run(0, cyc);
      chk("R9 halt cycles", 40'(cyc), 40'd3);
      begin
         int bad = 0;
         logic [9:0] a0;
         a0 = mem_addr;
         for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            if (mem_we || !done || mem_addr != a0) bad++;
         end
         chk("R9 quiet after halt", 40'(bad), 40'd0);
      end
      chk("R9 right slot skipped", mem[205], 40'h00_0001_2345);
      chk("R9 done held", 40'(done), 40'd1);

      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule